// File: doc/BRIEF.md
# Dual-Buffer Receive Frame Controller

This block is the receive half of a small Ethernet controller. Bytes of an incoming frame arrive on a valid/last stream. The block checks each frame's destination against a 48-bit station address, or lets it through when the frame is group-addressed. Frames that pass are written into one of two byte-wide receive buffers. Each buffer has its own control word. One bit of that word marks the buffer full, and a second bit asks for an interrupt when a frame lands there.

Software polls or takes the interrupt, reads the frame out through the host read port, and then writes the control word to hand the buffer back. With alternating mode on, successive accepted frames go to buffer 0, then buffer 1, then buffer 0 again. Software can therefore drain one buffer while the other fills. With alternating mode off, buffer 0 takes every frame. A frame is lost when it fails the address check, when the buffer it targets is still full, or when it is too long. A lost frame changes neither the control words nor which buffer comes next.

Top module: `rx_pingpong_buf`

## Requirements
- R1: After reset both control words read 0, `irq_pulse` is low, and the first accepted frame goes to buffer 0.
- R2: A frame is accepted when bit 7 of its first byte is 1. It is also accepted when its first six bytes equal `station_addr`, taking byte 0 from bits 47:40 and byte 5 from bits 7:0. Any other frame, including a frame shorter than six bytes whose first byte has bit 7 clear, is discarded.
- R3: A frame of MAX_LEN (default 2020) or more bytes is discarded. The buffers are written only at offsets below MAX_LEN-1.
- R4: A frame whose target buffer has its full bit set while the frame is arriving is discarded. That buffer's stored contents stay unchanged.
- R5: An accepted frame of n bytes occupies buffer offsets 0 to n-1. Its buffer's full bit (control bit 0) reads 1 from the cycle after the last byte.
- R6: `irq_pulse` is high for exactly one cycle, the cycle after the last byte of an accepted frame. It fires only when control bit 3 of the receiving buffer and `global_irq_en` are both 1.
- R7: With `pingpong_en` = 1, the target buffer flips after every accepted frame. With `pingpong_en` = 0, every frame targets buffer 0.
- R8: A discarded frame leaves both control words and the next target buffer unchanged.
- R9: The host address selects the following locations:
  - Control word of buffer p: 0x17FC + p*0x800. It reads {28'b0, bit3, 2'b0, bit0}, and a write stores wdata bits 3 and 0.
  - Byte k of buffer p: 0x1000 + p*0x800 + k, returned on `host_rdata[7:0]`.
  - Any address below 0x1000: reads 0.
  - Read timing: data appears the cycle after `host_rd` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inbound byte valid |
| in_data | input | 8 | Inbound frame byte |
| in_last | input | 1 | Marks the final byte of a frame |
| station_addr | input | 48 | Station address, byte 0 in bits 47:40 |
| pingpong_en | input | 1 | 1 = alternate buffers, 0 = buffer 0 only |
| global_irq_en | input | 1 | Global interrupt enable held outside the block |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe (control words only) |
| host_addr | input | BUF_AW+2 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one cycle after `host_rd` |
| irq_pulse | output | 1 | One-cycle receive interrupt |

## Verification
The target-buffer index is internal state, so the bench infers it from which control word gains its full bit. A wrong index shows up as the wrong bit, at the latest one frame later. An error in the per-frame drop flag or the header-match flag shows up as an acceptance error. A wrong flag makes a full bit appear or stay clear the cycle after the last byte. It also leaves an interrupt count that disagrees with the model right away. A write into a protected buffer is only visible once software reads that buffer. The bench therefore re-reads every full buffer after each frame, including frames that were discarded.

// File: rtl/rx_pp_pkg.sv
`timescale 1ns/1ps
package rx_pp_pkg;
  localparam int NUM_BUF    = 2;
  localparam int HDR_BYTES  = 6;
  localparam int CTRL_FULL  = 0;
  localparam int CTRL_IRQEN = 3;
endpackage

// File: rtl/rx_frame_judge.sv
`timescale 1ns/1ps
module rx_frame_judge import rx_pp_pkg::*; #(
  parameter int AW      = 11,
  parameter int MAX_LEN = 2020
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [7:0]         in_data,
  input  logic               in_last,
  input  logic [47:0]        station_addr,
  input  logic               target_port,
  input  logic [NUM_BUF-1:0] full_vec,
  output logic               we,
  output logic [AW-1:0]      waddr,
  output logic [7:0]         wdata,
  output logic               wport,
  output logic               commit,
  output logic               commit_port
);
  localparam int CW = $clog2(MAX_LEN + 1);
  localparam logic [CW-1:0] CUT_IDX  = CW'(MAX_LEN - 1);
  localparam logic [CW-1:0] HDR_LEN  = CW'(HDR_BYTES);
  localparam logic [CW-1:0] HDR_LAST = CW'(HDR_BYTES - 1);

  logic          in_frame, port_q, drop_q, match_q, group_q;
  logic [CW-1:0] cnt;

  logic       first, port_cur, in_hdr, match_cur, group_cur, too_long, drop_cur;
  logic [7:0] hdr_byte;
  int         hdr_idx;

  always_comb begin
    first     = !in_frame;
    port_cur  = first ? target_port : port_q;
    in_hdr    = cnt < HDR_LEN;
    hdr_idx   = in_hdr ? int'(cnt) : 0;
    hdr_byte  = station_addr[8*(HDR_BYTES-1-hdr_idx) +: 8];
    match_cur = (first | match_q) & (!in_hdr | (in_data == hdr_byte));
    group_cur = first ? in_data[7] : group_q;
    too_long  = cnt >= CUT_IDX;
    drop_cur  = (!first & drop_q) | full_vec[port_cur] | too_long;
  end

  assign we          = in_valid & !drop_cur;
  assign waddr       = AW'(cnt);
  assign wdata       = in_data;
  assign wport       = port_cur;
  assign commit      = in_valid & in_last & !drop_cur &
                       (group_cur | (match_cur & (cnt >= HDR_LAST)));
  assign commit_port = port_cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame <= 1'b0;
      port_q   <= 1'b0;
      drop_q   <= 1'b0;
      match_q  <= 1'b0;
      group_q  <= 1'b0;
      cnt      <= '0;
    end else if (in_valid) begin
      if (in_last) begin
        in_frame <= 1'b0;
        cnt      <= '0;
      end else begin
        in_frame <= 1'b1;
        cnt      <= too_long ? cnt : cnt + 1'b1;
      end
      port_q  <= port_cur;
      drop_q  <= drop_cur;
      match_q <= match_cur;
      group_q <= group_cur;
    end
  end
endmodule

// File: rtl/rx_buf_ram.sv
`timescale 1ns/1ps
module rx_buf_ram #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rx_ctrl_regs.sv
`timescale 1ns/1ps
module rx_ctrl_regs import rx_pp_pkg::*; (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_we,
  input  logic               host_port,
  input  logic               wr_irqen,
  input  logic               wr_full,
  input  logic               commit,
  input  logic               commit_port,
  input  logic               pingpong_en,
  input  logic               global_irq_en,
  output logic [NUM_BUF-1:0] full_vec,
  output logic [NUM_BUF-1:0] irqen_vec,
  output logic               active,
  output logic               target_port,
  output logic               irq_pulse
);
  assign target_port = pingpong_en & active;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_vec  <= '0;
      irqen_vec <= '0;
      active    <= 1'b0;
      irq_pulse <= 1'b0;
    end else begin
      irq_pulse <= commit & irqen_vec[commit_port] & global_irq_en;
      for (int p = 0; p < NUM_BUF; p++) begin
        if (host_we && host_port == 1'(p)) begin
          irqen_vec[p] <= wr_irqen;
          full_vec[p]  <= wr_full;
        end
        if (commit && commit_port == 1'(p)) full_vec[p] <= 1'b1;
      end
      if (commit) active <= pingpong_en ? ~active : 1'b0;
    end
  end
endmodule

// File: rtl/rx_pingpong_buf.sv
`timescale 1ns/1ps
module rx_pingpong_buf import rx_pp_pkg::*; #(
  parameter int BUF_AW  = 11,
  parameter int MAX_LEN = 2020
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic [47:0]       station_addr,
  input  logic              pingpong_en,
  input  logic              global_irq_en,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [BUF_AW+1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              irq_pulse
);
  typedef enum logic [1:0] {SEL_ZERO, SEL_RAM, SEL_REG} rsel_e;

  logic               rx_we, rx_wport, commit, commit_port, active, target_port;
  logic [BUF_AW-1:0]  rx_waddr;
  logic [7:0]         rx_wdata;
  logic [NUM_BUF-1:0] full_vec, irqen_vec;
  logic [7:0]         ram_q [NUM_BUF];

  logic rx_hit, reg_hit, host_port, host_we;
  assign rx_hit    = host_addr[BUF_AW+1];
  assign host_port = host_addr[BUF_AW];
  assign reg_hit   = &host_addr[BUF_AW-1:2];
  assign host_we   = host_wr & rx_hit & reg_hit;

  logic unused_bits;
  assign unused_bits = ^{host_wdata[31:4], host_wdata[2:1], host_addr[1:0]};

  rx_frame_judge #(.AW(BUF_AW), .MAX_LEN(MAX_LEN)) u_judge (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .station_addr(station_addr), .target_port(target_port), .full_vec(full_vec),
    .we(rx_we), .waddr(rx_waddr), .wdata(rx_wdata), .wport(rx_wport),
    .commit(commit), .commit_port(commit_port));

  rx_ctrl_regs u_regs (
    .clk(clk), .rst(rst), .host_we(host_we), .host_port(host_port),
    .wr_irqen(host_wdata[CTRL_IRQEN]), .wr_full(host_wdata[CTRL_FULL]),
    .commit(commit), .commit_port(commit_port), .pingpong_en(pingpong_en),
    .global_irq_en(global_irq_en), .full_vec(full_vec), .irqen_vec(irqen_vec),
    .active(active), .target_port(target_port), .irq_pulse(irq_pulse));

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_buf
    rx_buf_ram #(.AW(BUF_AW)) u_ram (
      .clk(clk), .we(rx_we && rx_wport == 1'(g)), .waddr(rx_waddr), .wdata(rx_wdata),
      .re(host_rd && rx_hit && host_port == 1'(g)), .raddr(host_addr[BUF_AW-1:0]),
      .rdata(ram_q[g]));
  end

  rsel_e       sel_q;
  logic        port_q;
  logic [31:0] reg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= SEL_ZERO;
      port_q <= 1'b0;
      reg_q  <= '0;
    end else if (host_rd) begin
      port_q <= host_port;
      reg_q  <= '0;
      reg_q[CTRL_IRQEN] <= irqen_vec[host_port];
      reg_q[CTRL_FULL]  <= full_vec[host_port];
      if (!rx_hit)      sel_q <= SEL_ZERO;
      else if (reg_hit) sel_q <= SEL_REG;
      else              sel_q <= SEL_RAM;
    end
  end

  always_comb begin
    case (sel_q)
      SEL_RAM: host_rdata = {24'b0, ram_q[port_q]};
      SEL_REG: host_rdata = reg_q;
      default: host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rx_pingpong_chk.sv
`timescale 1ns/1ps
module rx_pingpong_chk #(
  parameter int AW      = 11,
  parameter int MAX_LEN = 2020
) (
  input logic          clk,
  input logic          rst,
  input logic          rx_we,
  input logic [AW-1:0] rx_waddr,
  input logic          rx_wport,
  input logic          commit,
  input logic          commit_port,
  input logic [1:0]    full_vec,
  input logic          host_we,
  input logic          host_port,
  input logic          active,
  input logic          pingpong_en,
  input logic          global_irq_en,
  input logic          irq_pulse
);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    rx_we |-> (int'(rx_waddr) < MAX_LEN - 1));

  assert_no_write_full_R4: assert property (@(posedge clk) disable iff (rst)
    rx_we |-> !full_vec[rx_wport]);

  assert_no_commit_full_R4: assert property (@(posedge clk) disable iff (rst)
    commit |-> !full_vec[commit_port]);

  assert_full0_source_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(full_vec[0]) |-> ($past(commit && !commit_port) || $past(host_we && !host_port)));

  assert_full1_source_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(full_vec[1]) |-> ($past(commit && commit_port) || $past(host_we && host_port)));

  assert_irq_cause_R6: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> ($past(commit) && $past(global_irq_en)));

  assert_single_buf_R7: assert property (@(posedge clk) disable iff (rst)
    (commit && !pingpong_en) |=> !active);

  assert_index_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(active));
endmodule

bind rx_pingpong_buf rx_pingpong_chk #(.AW(BUF_AW), .MAX_LEN(MAX_LEN)) u_chk (
  .clk(clk), .rst(rst), .rx_we(rx_we), .rx_waddr(rx_waddr), .rx_wport(rx_wport),
  .commit(commit), .commit_port(commit_port), .full_vec(full_vec),
  .host_we(host_we), .host_port(host_port), .active(active),
  .pingpong_en(pingpong_en), .global_irq_en(global_irq_en), .irq_pulse(irq_pulse));

// File: tb/tb_rx_pingpong_buf.sv
`timescale 1ns/1ps
module tb_rx_pingpong_buf;
  localparam int AW = 11;
  localparam int MAXL = 2020;
  localparam logic [47:0] STA = 48'h021A2B3C4D5E;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 0, in_last = 0, pingpong_en = 1, global_irq_en = 1;
  logic host_rd = 0, host_wr = 0;
  logic [7:0] in_data = 0;
  logic [AW+1:0] host_addr = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  logic irq_pulse;

  always #5 clk = ~clk;

  rx_pingpong_buf #(.BUF_AW(AW), .MAX_LEN(MAXL)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .station_addr(STA), .pingpong_en(pingpong_en), .global_irq_en(global_irq_en),
    .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq_pulse(irq_pulse));

  int nchk = 0, nerr = 0, irq_seen = 0, exp_irq = 0;
  bit done = 0, exp_act = 0;
  bit exp_full [2], exp_ie [2];
  logic [7:0] frm [0:2047];
  logic [7:0] keep [2][0:2047];
  int keep_len [2];

  always @(negedge clk) if (!rst && irq_pulse) irq_seen++;

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic host_read(input int a, output int d);
    @(negedge clk); host_rd = 1; host_addr = (AW+2)'(a);
    @(negedge clk); host_rd = 0; d = int'(host_rdata);
  endtask

  task automatic set_ctrl(input int p, input bit ie, input bit full);
    @(negedge clk); host_wr = 1; host_addr = (AW+2)'('h17FC + p * 'h800);
    host_wdata = {28'b0, ie, 2'b0, full};
    @(negedge clk); host_wr = 0;
    exp_ie[p] = ie; exp_full[p] = full;
  endtask

  task automatic check_state(input string req);
    int d;
    for (int p = 0; p < 2; p++) begin
      host_read('h17FC + p * 'h800, d);
      chk({req, " ctrl"}, d, (exp_ie[p] ? 8 : 0) + (exp_full[p] ? 1 : 0));
    end
    chk("R6 irq count", irq_seen, exp_irq);
    for (int p = 0; p < 2; p++) begin
      if (exp_full[p]) begin
        for (int k = 0; k < keep_len[p]; k++) begin
          if (k < 12 || k == keep_len[p] - 1) begin
            host_read('h1000 + p * 'h800 + k, d);
            chk("R5 R4 contents", d, int'(keep[p][k]));
          end
        end
      end
    end
  endtask

  task automatic build(input int len, input int seed, input int mode, input int badpos);
    for (int i = 0; i < len; i++)
      frm[i] = (i < 6) ? STA[8*(5-i) +: 8] : 8'((i * 7 + seed) & 255);
    if (mode == 1) frm[0] = 8'h80 | 8'(seed & 127);
    if (mode == 2 && badpos < len) frm[badpos] = frm[badpos] ^ 8'h10;
  endtask

  task automatic send(input int len, input bit gap, input string req);
    bit m, acc;
    int tgt;
    m = (len >= 6);
    for (int i = 0; i < 6 && i < len; i++) if (frm[i] != STA[8*(5-i) +: 8]) m = 0;
    tgt = pingpong_en ? int'(exp_act) : 0;
    acc = (frm[0][7] || m) && !exp_full[tgt] && len < MAXL;
    for (int i = 0; i < len; i++) begin
      if (gap && i % 3 == 1) begin @(negedge clk); in_valid = 0; end
      @(negedge clk); in_valid = 1; in_data = frm[i]; in_last = (i == len - 1);
    end
    @(negedge clk); in_valid = 0; in_last = 0;
    if (acc) begin
      exp_full[tgt] = 1;
      if (exp_ie[tgt] && global_irq_en) exp_irq++;
      exp_act = pingpong_en ? !exp_act : 1'b0;
      for (int i = 0; i < len; i++) keep[tgt][i] = frm[i];
      keep_len[tgt] = len;
    end
    @(negedge clk);
    check_state(req);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int d;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state and R9 zero region
    host_read('h17FC, d); chk("R1 ctrl0", d, 0);
    host_read('h1FFC, d); chk("R1 ctrl1", d, 0);
    host_read('h0004, d); chk("R9 low region", d, 0);
    chk("R1 irq", int'(irq_pulse), 0);

    // R7 alternation, R1 first target, R6 interrupts, R4 lost when full
    set_ctrl(0, 1, 0); set_ctrl(1, 1, 0);
    build(20, 3, 0, 0); send(20, 0, "R1 R7 first to buf0");
    build(30, 9, 0, 0); send(30, 1, "R7 second to buf1");
    build(10, 5, 1, 0); send(10, 0, "R4 both full drop");

    // R2 filter sweep: corrupt each header byte
    set_ctrl(0, 1, 0); set_ctrl(1, 1, 0);
    for (int b = 0; b < 6; b++) begin
      build(16, b, 2, b); send(16, b[0], "R2 R8 mismatch");
    end
    for (int l = 1; l <= 6; l++) begin
      build(l, l, 0, 0); send(l, 0, "R2 short unicast");
    end
    build(1, 33, 1, 0); send(1, 0, "R2 group one byte");
    set_ctrl(0, 1, 0); set_ctrl(1, 1, 0);

    // R6 gating: global off, then per-buffer enable off
    global_irq_en = 0;
    build(12, 7, 1, 0); send(12, 0, "R6 global off");
    global_irq_en = 1;
    set_ctrl(1, 0, 0);
    build(12, 8, 0, 0); send(12, 1, "R6 ie off");
    set_ctrl(0, 1, 0); set_ctrl(1, 1, 0);

    // R3 length boundary
    for (int l = MAXL - 2; l <= MAXL + 1; l++) begin
      build(l, l, 0, 0); send(l, 0, "R3 R8 length");
      set_ctrl(0, 1, 0); set_ctrl(1, 1, 0);
    end

    // R7 single-buffer mode
    pingpong_en = 0;
    build(9, 11, 0, 0); send(9, 0, "R7 pp off first");
    build(9, 12, 0, 0); send(9, 0, "R7 R4 pp off buf0 full");
    set_ctrl(0, 1, 0);
    build(9, 13, 1, 0); send(9, 1, "R7 pp off again buf0");
    pingpong_en = 1;

    // R4 full set by host write blocks the target buffer
    set_ctrl(0, 1, 1); set_ctrl(1, 1, 0);
    build(14, 21, 0, 0); send(14, 0, "R4 host full");
    set_ctrl(0, 1, 0); set_ctrl(1, 1, 0);
    build(14, 22, 0, 0); send(14, 0, "R8 R9 next target");

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule